// File: doc/BRIEF.md
# 8x8 Inverse Transform and Reconstruction Engine

The engine rebuilds one 8x8 block of 8-bit pixels from 64 signed transform coefficients and an 8x8 block of prediction pixels. One shared eight-point inverse DCT datapath is used twice. First it processes the coefficient rows and writes each result transposed into a 16-bit intermediate store. Then it processes the rows of that store. Each of those final outputs goes down one pixel column. There it is scaled down with rounding, added to the matching prediction pixel and clamped to the 0..255 range.

Prediction rows are loaded one 8-pixel row per cycle, with a row index, while the engine is idle. A start pulse captures the whole coefficient block and the mode bit in the same cycle. In sparse mode only the first four coefficient rows are transformed, and the intermediate entries they do not write are zero. After both passes, the reconstructed rows leave in order 0 to 7 on consecutive cycles, and a done flag marks the last row.

Top module: `idct8_recon`

## Requirements
- R1: In full mode, output pixel (row j, column i) equals clamp(pred[j][i] + ((y + 16) >>> 5)). The row pass applies the eight-point inverse DCT to each coefficient row, with constants 16069, 15137, 13623, 11585, 9102, 6270 and 3196 for angles 4, 8, 12, 16, 20, 24 and 28 (in 64ths of pi), and rounds every product with (v + 8192) >>> 14. The column pass then applies the same transform to intermediate row i, and y is its output j. Coefficient n = row*8 + col sits at coef_blk bits [16n+15:16n], and pixel c of a row sits at bits [8c+7:8c].
- R2: Row-pass result k of coefficient row r is stored at intermediate position k*8 + r as a 16-bit two's-complement value, so a result outside that range wraps.
- R3: The residual is (y + 16) shifted right by 5 with sign extension: a DC coefficient of +64 adds 1 to every pixel and -64 subtracts 1.
- R4: A sum of prediction and residual above 255 is output as 255.
- R5: A sum of prediction and residual below 0 is output as 0.
- R6: With sparse_mode high at start, coefficient rows 4 to 7 have no effect: the output equals the full-mode result with those rows zero.
- R7: The reconstructed rows appear with rec_valid high on 8 consecutive cycles, rec_row counting 0 to 7, and rec_done is high together with row 7 only.
- R8: A start pulse while busy is high is ignored: the running block finishes unchanged and no second block follows.
- R9: Prediction writes while busy is high are ignored.
- R10: Count the clock edge that samples start as edge 1. rec_done is high after edge 25 in full mode and after edge 21 in sparse mode.
- R11: After reset, busy, rec_valid and rec_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one block when idle |
| sparse_mode | input | 1 | Transform only the first four coefficient rows |
| coef_blk | input | 1024 | 64 signed 16-bit coefficients, captured at start |
| pred_we | input | 1 | Write one prediction row |
| pred_row | input | 3 | Index of the prediction row being written |
| pred_row_pix | input | 64 | Eight prediction pixels |
| busy | output | 1 | Engine is processing a block |
| rec_valid | output | 1 | rec_pix holds a reconstructed row |
| rec_row | output | 3 | Index of the emitted row |
| rec_pix | output | 64 | Eight reconstructed pixels |
| rec_done | output | 1 | Last row of the block is on the output |

## Verification
A new start request and a prediction-row write can both arrive in a cycle where the engine is still transforming an earlier block. The bench provokes this by driving both, with inverted coefficients, a flipped mode and an all-0xFF prediction row, on one cycle in the middle of a job. It judges the result by requiring that every emitted row still matches the model of the original block, and that no further rows or busy cycles follow. A second overlap, the done flag landing in the same cycle as row 7, is judged for every job by the row-order check.

// File: rtl/idct8_recon_pkg.sv
package idct8_recon_pkg;
  localparam int BLK   = 8;
  localparam int IDX_W = $clog2(BLK);
  localparam int FRAC  = 14;
  // Rotation constants, angle k*pi/64 scaled by 2^14
  localparam int K04 = 16069;
  localparam int K08 = 15137;
  localparam int K12 = 13623;
  localparam int K16 = 11585;
  localparam int K20 = 9102;
  localparam int K24 = 6270;
  localparam int K28 = 3196;

  typedef enum logic [1:0] {ST_IDLE, ST_ROWS, ST_COLS, ST_EMIT} state_e;
endpackage

// File: rtl/idct8_core.sv
module idct8_core
  import idct8_recon_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int ACC_W = 48
) (
  input  logic signed [IN_W-1:0]  x_i [BLK],
  output logic signed [ACC_W-1:0] y_o [BLK]
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (FRAC - 1));
  localparam logic signed [ACC_W-1:0] C04 = ACC_W'(K04);
  localparam logic signed [ACC_W-1:0] C08 = ACC_W'(K08);
  localparam logic signed [ACC_W-1:0] C12 = ACC_W'(K12);
  localparam logic signed [ACC_W-1:0] C16 = ACC_W'(K16);
  localparam logic signed [ACC_W-1:0] C20 = ACC_W'(K20);
  localparam logic signed [ACC_W-1:0] C24 = ACC_W'(K24);
  localparam logic signed [ACC_W-1:0] C28 = ACC_W'(K28);

  function automatic logic signed [ACC_W-1:0] rshift(input logic signed [ACC_W-1:0] v);
    return (v + HALF) >>> FRAC;
  endfunction

  logic signed [ACC_W-1:0] e [BLK];
  logic signed [ACC_W-1:0] ev0, ev1, ev2, ev3, ev_a, ev_b, ev_c, ev_d;
  logic signed [ACC_W-1:0] od4, od5, od6, od7, od_m5, od_m6, od_s4, od_s7;

  always_comb begin
    for (int i = 0; i < BLK; i++) e[i] = ACC_W'(x_i[i]);
    // even half
    ev0  = rshift((e[0] + e[4]) * C16);
    ev1  = rshift((e[0] - e[4]) * C16);
    ev2  = rshift(e[2] * C24 - e[6] * C08);
    ev3  = rshift(e[2] * C08 + e[6] * C24);
    ev_a = ev0 + ev3;
    ev_b = ev1 + ev2;
    ev_c = ev1 - ev2;
    ev_d = ev0 - ev3;
    // odd half
    od4   = rshift(e[1] * C28 - e[7] * C04);
    od7   = rshift(e[1] * C04 + e[7] * C28);
    od5   = rshift(e[5] * C12 - e[3] * C20);
    od6   = rshift(e[5] * C20 + e[3] * C12);
    od_m5 = rshift((od7 - od6 - od4 + od5) * C16);
    od_m6 = rshift((od4 - od5 - od6 + od7) * C16);
    od_s4 = od4 + od5;
    od_s7 = od6 + od7;
    // butterfly out
    y_o[0] = ev_a + od_s7;
    y_o[1] = ev_b + od_m6;
    y_o[2] = ev_c + od_m5;
    y_o[3] = ev_d + od_s4;
    y_o[4] = ev_d - od_s4;
    y_o[5] = ev_c - od_m5;
    y_o[6] = ev_b - od_m6;
    y_o[7] = ev_a - od_s7;
  end
endmodule

// File: rtl/idct8_recon_lane.sv
module idct8_recon_lane #(
  parameter int ACC_W  = 48,
  parameter int PIX_W  = 8,
  parameter int RND_SH = 5
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [PIX_W-1:0]        pred_i,
  output logic signed [ACC_W-1:0] res_o,
  output logic [PIX_W-1:0]        pix_o
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (RND_SH - 1));
  localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] sum;

  always_comb begin
    res_o = (acc_i + HALF) >>> RND_SH;
    sum   = res_o + $signed({{(ACC_W - PIX_W){1'b0}}, pred_i});
    if (sum > PMAX)      pix_o = '1;
    else if (sum < 0)    pix_o = '0;
    else                 pix_o = sum[PIX_W-1:0];
  end
endmodule

// File: rtl/idct8_recon.sv
module idct8_recon
  import idct8_recon_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int MID_W  = 16,
  parameter int ACC_W  = 48,
  parameter int PIX_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        sparse_mode,
  input  logic [BLK*BLK*COEF_W-1:0]   coef_blk,
  input  logic                        pred_we,
  input  logic [IDX_W-1:0]            pred_row,
  input  logic [BLK*PIX_W-1:0]        pred_row_pix,
  output logic                        busy,
  output logic                        rec_valid,
  output logic [IDX_W-1:0]            rec_row,
  output logic [BLK*PIX_W-1:0]        rec_pix,
  output logic                        rec_done
);
  localparam int IN_W        = (COEF_W > MID_W) ? COEF_W : MID_W;
  localparam int NCOEF       = BLK * BLK;
  localparam int SPARSE_ROWS = BLK / 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK - 1);

  state_e st_q;
  logic [IDX_W-1:0] cnt_q;
  logic             sparse_q;

  logic signed [COEF_W-1:0] coef_q [NCOEF];
  logic signed [MID_W-1:0]  mid_q  [NCOEF];
  logic [PIX_W-1:0]         pred_q  [BLK][BLK];
  logic [PIX_W-1:0]         recon_q [BLK][BLK];

  logic signed [IN_W-1:0]  core_in  [BLK];
  logic signed [ACC_W-1:0] core_out [BLK];
  logic signed [ACC_W-1:0] res      [BLK];
  logic [PIX_W-1:0]        lane_pix [BLK];
  logic [IDX_W-1:0]        last_row;

  assign busy     = (st_q != ST_IDLE);
  assign last_row = sparse_q ? IDX_W'(SPARSE_ROWS - 1) : LAST_IDX;

  // Operand select: coefficient row in the row pass, intermediate row in the column pass
  always_comb begin
    for (int i = 0; i < BLK; i++) begin
      if (st_q == ST_COLS) core_in[i] = IN_W'(mid_q[{cnt_q, IDX_W'(i)}]);
      else                 core_in[i] = IN_W'(coef_q[{cnt_q, IDX_W'(i)}]);
    end
  end

  idct8_core #(.IN_W(IN_W), .ACC_W(ACC_W)) u_core (
    .x_i (core_in),
    .y_o (core_out)
  );

  for (genvar j = 0; j < BLK; j++) begin : g_lane
    idct8_recon_lane #(.ACC_W(ACC_W), .PIX_W(PIX_W), .RND_SH(5)) u_lane (
      .acc_i  (core_out[j]),
      .pred_i (pred_q[j][cnt_q]),
      .res_o  (res[j]),
      .pix_o  (lane_pix[j])
    );

    // R4: a non-negative residual never lowers the pixel
    p_no_drop_r4: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_COLS && res[j] >= 0) |-> (lane_pix[j] >= pred_q[j][cnt_q]));
    // R5: a negative residual never raises the pixel
    p_no_rise_r5: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_COLS && res[j] < 0) |-> (lane_pix[j] <= pred_q[j][cnt_q]));
  end

  for (genvar i = SPARSE_ROWS; i < BLK; i++) begin : g_sparse_chk
    // R6: entries not written by the sparse row pass read as zero
    p_sparse_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_COLS && sparse_q) |-> (core_in[i] == 0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sparse_q  <= 1'b0;
      rec_valid <= 1'b0;
      rec_done  <= 1'b0;
      rec_row   <= '0;
      rec_pix   <= '0;
    end else begin
      rec_valid <= 1'b0;
      rec_done  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (pred_we)
            for (int c = 0; c < BLK; c++)
              pred_q[pred_row][c] <= pred_row_pix[c*PIX_W +: PIX_W];
          if (start) begin
            for (int n = 0; n < NCOEF; n++) begin
              coef_q[n] <= coef_blk[n*COEF_W +: COEF_W];
              mid_q[n]  <= '0;
            end
            sparse_q <= sparse_mode;
            cnt_q    <= '0;
            st_q     <= ST_ROWS;
          end
        end
        ST_ROWS: begin
          for (int k = 0; k < BLK; k++)
            mid_q[{IDX_W'(k), cnt_q}] <= core_out[k][MID_W-1:0];
          if (cnt_q == last_row) begin
            cnt_q <= '0;
            st_q  <= ST_COLS;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_COLS: begin
          for (int j = 0; j < BLK; j++) recon_q[j][cnt_q] <= lane_pix[j];
          if (cnt_q == LAST_IDX) begin
            cnt_q <= '0;
            st_q  <= ST_EMIT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          rec_valid <= 1'b1;
          rec_row   <= cnt_q;
          rec_done  <= (cnt_q == LAST_IDX);
          for (int c = 0; c < BLK; c++) rec_pix[c*PIX_W +: PIX_W] <= recon_q[cnt_q][c];
          if (cnt_q == LAST_IDX) begin
            cnt_q <= '0;
            st_q  <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  // R7: done only together with the last row
  p_done_last_r7: assert property (@(posedge clk) disable iff (rst)
    rec_done |-> (rec_valid && rec_row == LAST_IDX));
  // R7: rows advance by one on consecutive cycles
  p_row_step_r7: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_row != LAST_IDX) |=> (rec_valid && rec_row == $past(rec_row) + 1'b1));
  // R7: the first emitted row is row 0
  p_first_row_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rec_valid) |-> (rec_row == '0));
  // R8: the engine only leaves idle on a start request
  p_start_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/idct8_recon_bench.sv
module idct8_recon_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sparse_mode = 1'b0;
  logic [1023:0] coef_blk = '0;
  logic pred_we = 1'b0;
  logic [2:0] pred_row = '0;
  logic [63:0] pred_row_pix = '0;
  logic busy, rec_valid, rec_done;
  logic [2:0] rec_row;
  logic [63:0] rec_pix;

  always #2.5 clk = ~clk;

  idct8_recon u_idct8_recon (
    .clk(clk), .rst(rst), .start(start), .sparse_mode(sparse_mode),
    .coef_blk(coef_blk), .pred_we(pred_we), .pred_row(pred_row),
    .pred_row_pix(pred_row_pix), .busy(busy), .rec_valid(rec_valid),
    .rec_row(rec_row), .rec_pix(rec_pix), .rec_done(rec_done)
  );

  typedef struct packed {
    int unsigned seed;
    int          amp;
    int          pbase;
    bit          sp;
    int          tag;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'd1,  200,   128, 1'b0, 1},
    '{32'd7,  2000,  30,  1'b0, 1},
    '{32'd9,  32767, 60,  1'b0, 2},
    '{32'd11, 300,   90,  1'b1, 6},
    '{32'd23, 32767, 200, 1'b1, 6},
    '{32'd5,  40,    250, 1'b0, 1}
  };

  int errs = 0;
  int checks = 0;
  shortint coef_m [64];
  int      pred_m [8][8];
  int      exp_m  [8][8];
  logic [63:0] got_q [8];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic longint rs(input longint v);
    return (v + 8192) >>> 14;
  endfunction

  function automatic void bidct(input longint a [8], output longint o [8]);
    longint b0, b1, b2, b3, s0, s1, s2, s3, s4, s5, s6, s7, t5, t6, a4, a7;
    b0 = rs((a[0] + a[4]) * 11585);
    b1 = rs((a[0] - a[4]) * 11585);
    b2 = rs(a[2] * 6270 - a[6] * 15137);
    b3 = rs(a[2] * 15137 + a[6] * 6270);
    s0 = b0 + b3; s1 = b1 + b2; s2 = b1 - b2; s3 = b0 - b3;
    s4 = rs(a[1] * 3196 - a[7] * 16069);
    s7 = rs(a[1] * 16069 + a[7] * 3196);
    s5 = rs(a[5] * 13623 - a[3] * 9102);
    s6 = rs(a[5] * 9102 + a[3] * 13623);
    t5 = rs((s7 - s6 - s4 + s5) * 11585);
    t6 = rs((s4 - s5 - s6 + s7) * 11585);
    a4 = s4 + s5; a7 = s6 + s7;
    o[0] = s0 + a7; o[1] = s1 + t6; o[2] = s2 + t5; o[3] = s3 + a4;
    o[4] = s3 - a4; o[5] = s2 - t5; o[6] = s1 - t6; o[7] = s0 - a7;
  endfunction

  // Expected block from the requirements (R1, R2, R3, R4, R5, R6)
  function automatic void model(input bit sp);
    longint mid [64];
    longint a [8];
    longint o [8];
    longint v;
    for (int n = 0; n < 64; n++) mid[n] = 0;
    for (int r = 0; r < (sp ? 4 : 8); r++) begin
      for (int c = 0; c < 8; c++) a[c] = longint'(coef_m[r*8 + c]);
      bidct(a, o);
      for (int k = 0; k < 8; k++) mid[k*8 + r] = longint'(shortint'(o[k]));
    end
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) a[j] = mid[i*8 + j];
      bidct(a, o);
      for (int j = 0; j < 8; j++) begin
        v = longint'(pred_m[j][i]) + ((o[j] + 16) >>> 5);
        exp_m[j][i] = (v > 255) ? 255 : (v < 0) ? 0 : int'(v);
      end
    end
  endfunction

  task automatic run_job(input bit sp, input bit disturb, input string tg);
    int cyc;
    int nxt;
    bit ord_ok;
    bit fin;
    bit quiet;
    logic [63:0] expr;
    model(sp);
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      pred_we = 1'b1;
      pred_row = 3'(r);
      for (int c = 0; c < 8; c++) pred_row_pix[c*8 +: 8] = 8'(pred_m[r][c]);
    end
    @(negedge clk);
    pred_we = 1'b0;
    for (int n = 0; n < 64; n++) coef_blk[n*16 +: 16] = coef_m[n];
    sparse_mode = sp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; nxt = 0; ord_ok = 1'b1; fin = 1'b0;
    for (int r = 0; r < 8; r++) got_q[r] = '0;
    while (!fin && cyc < 200) begin
      if (disturb && cyc == 4) begin
        start = 1'b1; sparse_mode = ~sp; coef_blk = ~coef_blk;
        pred_we = 1'b1; pred_row = 3'd0; pred_row_pix = '1;
      end
      @(negedge clk);
      cyc++;
      start = 1'b0;
      pred_we = 1'b0;
      if (rec_valid) begin
        if (rec_row != 3'(nxt)) ord_ok = 1'b0;
        got_q[rec_row] = rec_pix;
        nxt++;
      end else if (nxt > 0 && nxt < 8) ord_ok = 1'b0;
      if (rec_done) begin
        fin = 1'b1;
        if (!(rec_valid && rec_row == 3'd7)) ord_ok = 1'b0;
      end
    end
    check(fin, "R10", "job finished", longint'(fin), 1);
    check(cyc == (sp ? 21 : 25), "R10", "done latency", cyc, sp ? 21 : 25);
    check(ord_ok && nxt == 8, "R7", "row order", nxt, 8);
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) expr[c*8 +: 8] = 8'(exp_m[r][c]);
      check(got_q[r] == expr, tg, $sformatf("row %0d", r), got_q[r], expr);
    end
    if (disturb) begin
      quiet = 1'b1;
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        if (rec_valid || busy) quiet = 1'b0;
      end
      check(quiet, "R8", "no second job", longint'(quiet), 1);
    end
  endtask

  task automatic set_dc(input int dc, input int pv);
    for (int n = 0; n < 64; n++) coef_m[n] = 0;
    coef_m[0] = shortint'(dc);
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) pred_m[r][c] = pv;
  endtask

  initial begin
    #1ms;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    longint unsigned s;
    longint span;
    string tg;
    repeat (4) @(negedge clk);
    check(!busy && !rec_valid && !rec_done, "R11", "reset state",
          {busy, rec_valid, rec_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !rec_valid && !rec_done, "R11", "idle after reset",
          {busy, rec_valid, rec_done}, 0);

    // Vector table walk: R1 dense, R2 wide values, R6 sparse with junk in rows 4..7
    for (int v = 0; v < 6; v++) begin
      s = VEC[v].seed;
      span = 2 * longint'(VEC[v].amp) + 1;
      for (int n = 0; n < 64; n++) begin
        s = (s * 1103515245 + 12345) & 64'hFFFF_FFFF;
        coef_m[n] = shortint'(longint'((s >> 8) % span) - VEC[v].amp);
      end
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++) begin
          s = (s * 1103515245 + 12345) & 64'hFFFF_FFFF;
          pred_m[r][c] = (VEC[v].pbase + r*13 + c*7 + int'((s >> 16) % 24)) % 256;
        end
      tg = (VEC[v].tag == 2) ? "R2" : (VEC[v].tag == 6) ? "R6" : "R1";
      run_job(VEC[v].sp, 1'b0, tg);
    end

    // R3: rounding with sign-extending shift
    set_dc(64, 100);
    run_job(1'b0, 1'b0, "R3");
    check(got_q[3] == {8{8'd101}}, "R3", "dc +64", got_q[3], {8{8'd101}});
    set_dc(-64, 100);
    run_job(1'b0, 1'b0, "R3");
    check(got_q[5] == {8{8'd99}}, "R3", "dc -64", got_q[5], {8{8'd99}});

    // R4 / R5: clamps
    set_dc(2000, 250);
    run_job(1'b0, 1'b0, "R4");
    check(got_q[0] == {8{8'd255}}, "R4", "clamp high", got_q[0], {8{8'd255}});
    set_dc(-2000, 5);
    run_job(1'b1, 1'b0, "R5");
    check(got_q[7] == 64'd0, "R5", "clamp low", got_q[7], 0);

    // R8 R9: start and prediction write arrive while busy
    s = 77;
    for (int n = 0; n < 64; n++) begin
      s = (s * 1103515245 + 12345) & 64'hFFFF_FFFF;
      coef_m[n] = shortint'(longint'((s >> 8) % 801) - 400);
    end
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) pred_m[r][c] = 40 + r*20 + c;
    run_job(1'b0, 1'b1, "R9");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule